// File: doc/BRIEF.md
# Table-Driven Phase Sequencer with Branching

This block is the digital control unit of a hybrid analog computing set-up. It moves a program through a series of numbered steps. For each step it drives three things: a mode word with one bit per integrator, a single freeze line shared by all integrators, and the length of the current time segment. When a segment's time has run out, the sequencer picks its next step from a reloadable table. The table is indexed by the current step and by the comparator bits that the step's own mask lets through. A program can therefore run straight through, branch on a zero crossing, or loop through setup, compute and compare until a convergence bit rises.

A host loads the step words and the next-step table through a one-cycle write port while the sequencer is idle. A start pulse then launches the program at step 0. The program ends when it enters a step marked as a stop step. At that point the sequencer is idle again, reports completion, and keeps every integrator frozen.

Top module: `phase_sequencer`

## Requirements
- R1: After reset, busy_o and done_o are 0, halt_o is 1, mode_o is all zeros and step_o is 0.
- R2: A start_i pulse while idle makes step 0 current on the next cycle. While running, mode_o and halt_o show the mode and freeze fields of the current step word. A word written with wr_kind_i=0 is laid out as mode in bits [7:0], duration in [23:8], condition mask in [27:24], freeze in bit 28 and stop in bit 29.
- R3: A running step stays current for exactly its duration in clock cycles, and seg_len_o shows that length. A duration of 0 runs for one cycle.
- R4: At the end of a segment, the next step is the table entry at row = current step and column = (synchronised conditions AND the step's mask), so masked-off bits read as 0. A write with wr_kind_i=1 stores wr_data_i[3:0] at row wr_row_i, column wr_col_i.
- R5: Condition inputs pass through two flops. A change takes part in a branch only if cond_i held the new value at the clock edge two cycles before the edge that ends the segment.
- R6: Entering a step whose stop bit is set makes the block idle on that same edge. busy_o goes to 0, done_o goes to 1, halt_o goes to 1, mode_o goes to zeros, and step_o shows the stop step. done_o stays 1 until the next start clears it.
- R7: Writes presented while busy_o is 1 leave both the step words and the table unchanged.
- R8: A start_i pulse while busy_o is 1 does not disturb the running sequence.
- R9: A program of setup, operate and freeze-and-compare steps repeats until a masked condition bit selects a stop step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch the program at step 0 (idle only) |
| cond_i | input | 4 | Asynchronous comparator bits |
| wr_en_i | input | 1 | Write strobe for the tables |
| wr_kind_i | input | 1 | 0 = step word, 1 = next-step entry |
| wr_row_i | input | 4 | Step number being written |
| wr_col_i | input | 4 | Condition column for next-step writes |
| wr_data_i | input | 30 | Step word or next-step number |
| busy_o | output | 1 | Program running |
| done_o | output | 1 | Program reached a stop step |
| halt_o | output | 1 | Freeze all integrators |
| mode_o | output | 8 | Per-integrator operate (1) / initial-condition (0) |
| step_o | output | 4 | Current step number |
| seg_len_o | output | 16 | Cycles in the current segment |

## Verification
A corrupted step register shows up on step_o, mode_o and halt_o in the very next cycle. The scoreboard compares all three against its own model of the program at every segment boundary. A timer that is off by even one cycle changes the measured segment length, and that length is checked for every step. A wrong table lookup or a mistake in synchronisation timing sends the program to a different step at the first branch, which is caught when that segment is popped. Writes that should have been ignored are exposed by running the same program again afterwards.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

    localparam int unsigned NUM_STEPS   = 16;
    localparam int unsigned NUM_COND    = 4;
    localparam int unsigned NUM_INTEG   = 8;
    localparam int unsigned DUR_W       = 16;
    localparam int unsigned SYNC_STAGES = 2;

    localparam int unsigned STEP_W    = $clog2(NUM_STEPS);
    localparam int unsigned NUM_COLS  = 1 << NUM_COND;
    localparam int unsigned TBL_DEPTH = NUM_STEPS * NUM_COLS;
    localparam int unsigned TBL_AW    = STEP_W + NUM_COND;
    localparam int unsigned WORD_W    = NUM_INTEG + DUR_W + NUM_COND + 2;

    typedef logic [STEP_W-1:0]    step_t;
    typedef logic [NUM_COND-1:0]  cond_t;
    typedef logic [DUR_W-1:0]     dur_t;
    typedef logic [NUM_INTEG-1:0] mode_t;
    typedef logic [TBL_AW-1:0]    tbl_addr_t;

    // Step word, most significant field first.
    typedef struct packed {
        logic  stop;
        logic  halt;
        cond_t mask;
        dur_t  dur;
        mode_t mode;
    } step_word_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } seq_state_e;

    typedef enum logic {
        WR_WORD = 1'b0,
        WR_NEXT = 1'b1
    } wr_kind_e;

    // A zero duration still occupies one cycle.
    function automatic dur_t eff_len(input dur_t d);
        return (d == '0) ? dur_t'(1) : d;
    endfunction

    function automatic tbl_addr_t tbl_index(input step_t row, input cond_t col);
        return {row, col};
    endfunction

endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic [W-1:0] q_r;
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) q_r <= '0;
                    else     q_r <= d;
                end
            end else begin : g_chain
                always_ff @(posedge clk) begin
                    if (rst) q_r <= '0;
                    else     q_r <= g_stage[s-1].q_r;
                end
            end
        end
    endgenerate

    assign q = g_stage[STAGES-1].q_r;

endmodule

// File: rtl/ps_step_store.sv
module ps_step_store
    import phase_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  step_t      wr_addr,
    input  step_word_t wr_word,
    input  step_t      cur_addr,
    output mode_t      cur_mode,
    output logic       cur_halt,
    output cond_t      cur_mask,
    output dur_t       cur_dur,
    input  step_t      peek_addr,
    output logic       peek_stop,
    output dur_t       peek_dur
);

    step_word_t mem [NUM_STEPS];
    step_word_t cur_w;
    step_word_t peek_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NUM_STEPS); i++) mem[i] <= '0;
        end else if (we) begin
            mem[wr_addr] <= wr_word;
        end
    end

    // Current-step port: feeds the outputs and the branch mask.
    assign cur_w    = mem[cur_addr];
    assign cur_mode = cur_w.mode;
    assign cur_halt = cur_w.halt;
    assign cur_mask = cur_w.mask;
    assign cur_dur  = cur_w.dur;

    // Look-ahead port: the step about to be entered.
    assign peek_w    = mem[peek_addr];
    assign peek_stop = peek_w.stop;
    assign peek_dur  = peek_w.dur;

endmodule

// File: rtl/ps_next_table.sv
module ps_next_table
    import phase_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  step_t wr_row,
    input  cond_t wr_col,
    input  step_t wr_next,
    input  step_t rd_row,
    input  cond_t rd_col,
    output step_t rd_next
);

    step_t tbl [TBL_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(TBL_DEPTH); i++) tbl[i] <= '0;
        end else if (we) begin
            tbl[tbl_index(wr_row, wr_col)] <= wr_next;
        end
    end

    assign rd_next = tbl[tbl_index(rd_row, rd_col)];

endmodule

// File: rtl/ps_seg_timer.sv
module ps_seg_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);

    logic [W-1:0] cnt;

    // Counts down to zero; zero marks the final cycle of a segment.
    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);

endmodule

// File: rtl/phase_sequencer.sv
module phase_sequencer
    import phase_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [NUM_COND-1:0]  cond_i,
    input  logic                 wr_en_i,
    input  logic                 wr_kind_i,
    input  logic [STEP_W-1:0]    wr_row_i,
    input  logic [NUM_COND-1:0]  wr_col_i,
    input  logic [WORD_W-1:0]    wr_data_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 halt_o,
    output logic [NUM_INTEG-1:0] mode_o,
    output logic [STEP_W-1:0]    step_o,
    output logic [DUR_W-1:0]     seg_len_o
);

    seq_state_e state;
    step_t      cur_step;
    logic       done_r;

    cond_t      cond_s;
    cond_t      sel_cond;
    mode_t      cur_mode;
    logic       cur_halt;
    cond_t      cur_mask;
    dur_t       cur_dur;
    step_t      nxt_step;
    step_t      tgt_step;
    logic       peek_stop;
    dur_t       peek_dur;
    logic       go;
    logic       seg_last;
    logic       wr_ok;
    logic       running;

    assign running = (state == PH_RUN);
    assign wr_ok   = wr_en_i && !running;

    ps_sync #(
        .W      (NUM_COND),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (cond_i),
        .q   (cond_s)
    );

    ps_step_store u_store (
        .clk       (clk),
        .rst       (rst),
        .we        (wr_ok && (wr_kind_i == WR_WORD)),
        .wr_addr   (wr_row_i),
        .wr_word   (step_word_t'(wr_data_i)),
        .cur_addr  (cur_step),
        .cur_mode  (cur_mode),
        .cur_halt  (cur_halt),
        .cur_mask  (cur_mask),
        .cur_dur   (cur_dur),
        .peek_addr (tgt_step),
        .peek_stop (peek_stop),
        .peek_dur  (peek_dur)
    );

    // Masked-off condition bits take part as zeros.
    assign sel_cond = cond_s & cur_mask;

    ps_next_table u_table (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_ok && (wr_kind_i == WR_NEXT)),
        .wr_row  (wr_row_i),
        .wr_col  (wr_col_i),
        .wr_next (wr_data_i[STEP_W-1:0]),
        .rd_row  (cur_step),
        .rd_col  (sel_cond),
        .rd_next (nxt_step)
    );

    ps_seg_timer #(
        .W (DUR_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (go && !peek_stop),
        .load_val (eff_len(peek_dur) - dur_t'(1)),
        .last     (seg_last)
    );

    // Step entry: a start from idle, or the final cycle of a running segment.
    always_comb begin
        go       = 1'b0;
        tgt_step = cur_step;
        if (!running) begin
            if (start_i) begin
                go       = 1'b1;
                tgt_step = '0;
            end
        end else if (seg_last) begin
            go       = 1'b1;
            tgt_step = nxt_step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PH_IDLE;
            cur_step <= '0;
            done_r   <= 1'b0;
        end else if (go) begin
            cur_step <= tgt_step;
            if (peek_stop) begin
                state  <= PH_IDLE;
                done_r <= 1'b1;
            end else begin
                state  <= PH_RUN;
                done_r <= 1'b0;
            end
        end
    end

    assign busy_o    = running;
    assign done_o    = done_r;
    assign halt_o    = !running || cur_halt;
    assign mode_o    = running ? cur_mode : '0;
    assign step_o    = cur_step;
    assign seg_len_o = running ? eff_len(cur_dur) : '0;

endmodule

// File: rtl/phase_sequencer_chk.sv
module phase_sequencer_chk #(
    parameter int unsigned STEP_W    = 4,
    parameter int unsigned NUM_INTEG = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start_i,
    input logic                 busy_o,
    input logic                 done_o,
    input logic                 halt_o,
    input logic [NUM_INTEG-1:0] mode_o,
    input logic [STEP_W-1:0]    step_o,
    input logic                 seg_last
);

    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy_o && !seg_last |=> busy_o && $stable(step_o)); // R3

    AST_START_STEP0: assert property (@(posedge clk) disable iff (rst)
        !busy_o && start_i |=> step_o == '0); // R2

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o && halt_o && mode_o == '0); // R6

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst)
        done_o && !start_i |=> done_o); // R6

endmodule

bind phase_sequencer phase_sequencer_chk #(
    .STEP_W    (phase_seq_pkg::STEP_W),
    .NUM_INTEG (phase_seq_pkg::NUM_INTEG)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .halt_o   (halt_o),
    .mode_o   (mode_o),
    .step_o   (step_o),
    .seg_last (seg_last)
);

// File: tb/phase_sequencer_bench.sv
`timescale 1ns/1ps
module phase_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [3:0]  cond_i = '0;
    logic        wr_en_i = 1'b0;
    logic        wr_kind_i = 1'b0;
    logic [3:0]  wr_row_i = '0;
    logic [3:0]  wr_col_i = '0;
    logic [29:0] wr_data_i = '0;
    logic        busy_o;
    logic        done_o;
    logic        halt_o;
    logic [7:0]  mode_o;
    logic [3:0]  step_o;
    logic [15:0] seg_len_o;

    always #2 clk = ~clk;

    phase_sequencer u_phase_sequencer (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .cond_i    (cond_i),
        .wr_en_i   (wr_en_i),
        .wr_kind_i (wr_kind_i),
        .wr_row_i  (wr_row_i),
        .wr_col_i  (wr_col_i),
        .wr_data_i (wr_data_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .halt_o    (halt_o),
        .mode_o    (mode_o),
        .step_o    (step_o),
        .seg_len_o (seg_len_o)
    );

    typedef struct {
        int step;
        int len;
        int mode;
        int halt;
        bit stop;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_err = 0;

    int m_mode [16];
    int m_halt [16];
    int m_mask [16];
    int m_dur  [16];
    int m_stop [16];
    int m_next [16][16];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- write drivers ----------------
    task automatic raw_word(input int row, input int stop, input int halt,
                            input int mask, input int dur, input int mode);
        wr_en_i   = 1'b1;
        wr_kind_i = 1'b0;
        wr_row_i  = 4'(row);
        wr_data_i = {1'(stop), 1'(halt), 4'(mask), 16'(dur), 8'(mode)};
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic raw_next(input int row, input int col, input int nxt);
        wr_en_i   = 1'b1;
        wr_kind_i = 1'b1;
        wr_row_i  = 4'(row);
        wr_col_i  = 4'(col);
        wr_data_i = 30'(nxt);
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic set_word(input int row, input int stop, input int halt,
                            input int mask, input int dur, input int mode);
        m_stop[row] = stop; m_halt[row] = halt; m_mask[row] = mask;
        m_dur[row]  = dur;  m_mode[row] = mode;
        raw_word(row, stop, halt, mask, dur, mode);
    endtask

    task automatic set_next(input int row, input int col, input int nxt);
        m_next[row][col] = nxt;
        raw_next(row, col, nxt);
    endtask

    task automatic set_row(input int row, input int nxt);
        for (int c = 0; c < 16; c++) set_next(row, c, nxt);
    endtask

    // ---------------- expectation builder ----------------
    task automatic push_seg(input int s);
        exp_t e;
        e.step = s; e.len = (m_dur[s] == 0) ? 1 : m_dur[s];
        e.mode = m_mode[s]; e.halt = m_halt[s]; e.stop = 1'b0;
        q.push_back(e);
    endtask

    task automatic push_stop(input int s);
        exp_t e;
        e.step = s; e.len = 0; e.mode = 0; e.halt = 1; e.stop = 1'b1;
        q.push_back(e);
    endtask

    // Follows the program with the conditions held constant.
    task automatic expect_run(input int cond);
        int s = 0;
        for (int k = 0; k < 64; k++) begin
            if (m_stop[s] != 0) begin
                push_stop(s);
                break;
            end
            push_seg(s);
            s = m_next[s][cond & m_mask[s]];
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!(done_o && !busy_o)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // ---------------- monitor ----------------
    bit   mon_active = 1'b0;
    bit   prev_busy  = 1'b0;
    int   mon_len, mon_step, mon_mode, mon_halt, mon_slen;

    task automatic close_seg();
        exp_t e;
        if (q.size() == 0) begin
            chk("R4 unexpected segment", mon_step, -1);
            return;
        end
        e = q.pop_front();
        chk("R4 step order", mon_step, e.step);
        chk("R6 segment where stop expected", int'(e.stop), 0);
        chk("R3 segment length", mon_len, e.len);
        chk("R3 seg_len_o", mon_slen, e.len);
        chk("R2 mode_o", mon_mode, e.mode);
        chk("R2 halt_o", mon_halt, e.halt);
    endtask

    task automatic close_stop();
        exp_t e;
        if (q.size() == 0) begin
            chk("R6 unexpected stop", int'(step_o), -1);
            return;
        end
        e = q.pop_front();
        chk("R6 stop expected", int'(e.stop), 1);
        chk("R6 stop step", int'(step_o), e.step);
        chk("R6 done_o", int'(done_o), 1);
        chk("R6 halt_o", int'(halt_o), 1);
        chk("R6 mode_o", int'(mode_o), 0);
    endtask

    always @(negedge clk) begin
        if (rst) begin
            mon_active = 1'b0;
            prev_busy  = 1'b0;
        end else begin
            if (busy_o) begin
                if (mon_active && int'(step_o) == mon_step) begin
                    mon_len++;
                end else begin
                    if (mon_active) close_seg();
                    mon_active = 1'b1;
                    mon_step   = int'(step_o);
                    mon_len    = 1;
                    mon_mode   = int'(mode_o);
                    mon_halt   = int'(halt_o);
                    mon_slen   = int'(seg_len_o);
                end
            end else if (prev_busy) begin
                if (mon_active) close_seg();
                mon_active = 1'b0;
                close_stop();
            end
            prev_busy = busy_o;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 16; i++) begin
            m_mode[i] = 0; m_halt[i] = 0; m_mask[i] = 0; m_dur[i] = 0; m_stop[i] = 0;
            for (int j = 0; j < 16; j++) m_next[i][j] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy_o", int'(busy_o), 0);
        chk("R1 done_o", int'(done_o), 0);
        chk("R1 halt_o", int'(halt_o), 1);
        chk("R1 mode_o", int'(mode_o), 0);
        chk("R1 step_o", int'(step_o), 0);

        // Linear program with a zero-duration step (R2, R3, R6)
        set_word(0, 0, 0, 0, 4, 8'h00); set_row(0, 1);
        set_word(1, 0, 0, 0, 0, 8'hA5); set_row(1, 2);
        set_word(2, 0, 0, 0, 6, 8'hFF); set_row(2, 3);
        set_word(3, 0, 1, 0, 2, 8'h0F); set_row(3, 4);
        set_word(4, 1, 1, 0, 0, 8'h00);
        cond_i = 4'b0101;
        repeat (3) @(negedge clk);
        expect_run(5);
        pulse_start();
        chk("R2 busy after start", int'(busy_o), 1);
        wait_done();

        // R7 and R8: writes and start during a run have no effect
        expect_run(5);
        pulse_start();
        chk("R6 done cleared by start", int'(done_o), 0);
        raw_word(2, 0, 0, 0, 6, 8'h3C);   // R7 ignored write
        raw_next(1, 0, 4);                // R7 ignored write
        start_i = 1'b1;                   // R8 ignored start
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        expect_run(5);                    // R7 rerun shows old contents
        pulse_start();
        wait_done();

        // R4: masked branch; mask 0110 on step 0
        set_word(0, 0, 0, 4'b0110, 3, 8'h11);
        for (int c = 0; c < 16; c++) set_next(0, c, 9);
        set_next(0, 4'b0000, 8);
        set_next(0, 4'b0010, 5);
        set_next(0, 4'b0100, 6);
        set_next(0, 4'b0110, 7);
        for (int s = 5; s <= 9; s++) set_word(s, 1, 1, 0, 0, 0);
        foreach (m_stop[i]) if (0) m_stop[i] = 0;
        begin
            int pats[4] = '{4'b1011, 4'b1101, 4'b1111, 4'b1001};
            for (int p = 0; p < 4; p++) begin
                cond_i = 4'(pats[p]);
                repeat (3) @(negedge clk);
                expect_run(pats[p]);      // R4 expected 5,6,7,8
                pulse_start();
                wait_done();
            end
        end

        // R5: synchroniser latency at the segment end
        set_word(0, 0, 0, 4'b0001, 10, 8'h22);
        set_row(0, 6);
        set_next(0, 1, 5);
        for (int late = 0; late < 2; late++) begin
            cond_i = 4'b0000;
            repeat (3) @(negedge clk);
            push_seg(0);
            push_stop(late == 0 ? 5 : 6);
            pulse_start();
            repeat (7 + late) @(negedge clk);
            cond_i = 4'b0001;
            wait_done();
        end

        // R9: iterate setup/operate/compare until convergence
        set_word(0, 0, 0, 0, 3, 8'h00);      set_row(0, 1);
        set_word(1, 0, 0, 0, 5, 8'hFF);      set_row(1, 2);
        set_word(2, 0, 1, 4'b0001, 2, 8'hFF); set_row(2, 0);
        set_next(2, 1, 3);
        set_word(3, 1, 1, 0, 0, 0);
        cond_i = 4'b0000;
        repeat (3) @(negedge clk);
        for (int it = 0; it < 3; it++) begin
            push_seg(0); push_seg(1); push_seg(2);
        end
        push_stop(3);
        pulse_start();
        begin
            int entries = 0;
            int prev = -1;
            while (entries < 3) begin
                if (busy_o && step_o == 4'd1 && prev != 1) entries++;
                prev = busy_o ? int'(step_o) : -1;
                if (entries < 3) @(negedge clk);
            end
        end
        cond_i = 4'b0001;                 // R9 convergence flag
        wait_done();

        // R6: step 0 itself is a stop step
        set_word(0, 1, 0, 0, 7, 8'h77);
        pulse_start();
        chk("R6 immediate stop busy_o", int'(busy_o), 0);
        chk("R6 immediate stop done_o", int'(done_o), 1);
        chk("R6 immediate stop step_o", int'(step_o), 0);
        chk("R6 immediate stop halt_o", int'(halt_o), 1);

        repeat (3) @(negedge clk);
        chk("R9 scoreboard drained", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule